// File: doc/BRIEF.md
# Triangular Single-Parity-Check Encoder

This block is a systematic encoder for a two-dimensional triangular single-parity-check LDPC code. The code is sized by the triangle edge `N`, which defaults to 5. It takes `K = N(N-1)/2` data bits in one parallel word. It returns a codeword of `L = N(N+1)/2` bits: the data unchanged, followed by `N` parity bits.

Each data bit is tied to one unordered pair `(i, j)` of parity positions, with `i < j`. Data bits are numbered in lexicographic pair order: (0,1), (0,2), …, (0,N-1), (1,2), and so on. A parity bit is the XOR of every data bit whose pair names its position. Every data bit therefore feeds exactly two parity bits. The code rate is `(N-1)/(N+1)` and the minimum distance is 3.

Both sides are valid/ready streams. A word moves on a cycle where its valid and ready are both high at the rising clock edge. The encoder holds one output register. While that register is full and the consumer drives `out_ready` low, the encoder deasserts `in_ready` and the held codeword does not change. When the consumer takes the word, a new word may be accepted in the same cycle, so the block can pass one word per cycle.

Top module: `tspc_encoder`

## Requirements
- R1: The codeword bits `out_cw[K-1:0]` equal the data word accepted on the previous transfer, in the same bit order.
- R2: Parity position `p` (0-based) is at `out_cw[K+p]`. It is the XOR of the data bits whose pair contains `p`. Pair `(i,j)` with `i<j` is data bit `i*N - i*(i+1)/2 + (j-i-1)`.
- R3: Whenever `out_valid` is high, the XOR of all `N` parity bits is 0. This is the extra check equation that joins the parity bits.
- R4: An input transfer (`in_valid && in_ready` at a rising edge) makes `out_valid` high after that edge.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_cw` hold their values, and changes on `in_data` have no effect.
- R7: A synchronous active-high `rst` clears `out_valid` at the next rising edge.
- R8: With `out_ready` held high, a new word is accepted on every cycle. The codewords come out in order, one per cycle.
- R9: A data word with a single bit set encodes to a codeword of Hamming weight 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Encoder can take a word |
| in_data | input | K | Data bits; bit 0 belongs to pair (0,1) |
| out_valid | output | 1 | Codeword present |
| out_ready | input | 1 | Consumer takes the codeword |
| out_cw | output | L | Data in bits K-1:0, parity in bits L-1:K |

## Verification
The case that is hardest to reach from the ports is a long stall in which `in_valid` stays high and `in_data` keeps changing. The held codeword must not change, and nothing offered during the stall may be accepted. The bench drives that case directly: it holds `out_ready` low for several cycles while it changes the offered data on every cycle. It then releases `out_ready` and checks that the first word after the stall is the one offered at release. The same run also covers a reset issued while a codeword is pending.

// File: rtl/tspc_pkg.sv
package tspc_pkg;

  function automatic int data_len(input int n);
    return n * (n - 1) / 2;
  endfunction

  function automatic int code_len(input int n);
    return n * (n + 1) / 2;
  endfunction

  // Data bit that belongs to parity pair (lo, hi), lo < hi, lexicographic order.
  function automatic int pair_index(input int lo, input int hi, input int n);
    return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

endpackage

// File: rtl/tspc_parity_net.sv
module tspc_parity_net #(
  parameter int N = 5,
  localparam int K = tspc_pkg::data_len(N)
) (
  input  logic [K-1:0] data,
  output logic [N-1:0] parity
);
  import tspc_pkg::*;

  for (genvar p = 0; p < N; p++) begin : g_par
    logic [N-2:0] taps;
    for (genvar q = 0; q < N - 1; q++) begin : g_tap
      localparam int OTHER = (q < p) ? q : q + 1;
      localparam int LO    = (p < OTHER) ? p : OTHER;
      localparam int HI    = (p < OTHER) ? OTHER : p;
      assign taps[q] = data[pair_index(LO, HI, N)];
    end
    assign parity[p] = ^taps;
  end

endmodule

// File: rtl/tspc_out_stage.sv
module tspc_out_stage #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic load;

  assign up_ready = !dn_valid || dn_ready;
  assign load     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst)           dn_valid <= 1'b0;
    else if (load)     dn_valid <= 1'b1;
    else if (dn_ready) dn_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dn_data <= up_data;
  end

  assert_accept_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |=> dn_valid);

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> !dn_valid);

endmodule

// File: rtl/tspc_encoder.sv
module tspc_encoder #(
  parameter int N = 5,
  localparam int K = tspc_pkg::data_len(N),
  localparam int L = tspc_pkg::code_len(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [L-1:0] out_cw
);
  logic [N-1:0] parity;
  logic [L-1:0] cw_next;

  tspc_parity_net #(.N(N)) u_parity (
    .data   (in_data),
    .parity (parity)
  );

  assign cw_next = {parity, in_data};

  tspc_out_stage #(.W(L)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (cw_next),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_cw)
  );

  assert_systematic_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_cw[K-1:0] == $past(in_data)));

  assert_parity_even_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^out_cw[L-1:K] == 1'b0));

endmodule

// File: tb/tspc_encoder_test.sv
`timescale 1ns/1ps
module tspc_encoder_test;
  localparam int N = 5;
  localparam int K = N * (N - 1) / 2;
  localparam int L = N * (N + 1) / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [K-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [L-1:0] out_cw;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  tspc_encoder #(.N(N)) uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_cw(out_cw)
  );

  // Walks the pairs in order; every set data bit flips both of its parities.
  function automatic logic [L-1:0] ref_encode(input logic [K-1:0] d);
    logic [N-1:0] par = '0;
    int idx = 0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        if (d[idx]) begin
          par[i] = ~par[i];
          par[j] = ~par[j];
        end
        idx++;
      end
    return {par, d};
  endfunction

  logic         m_valid = 1'b0;
  logic [L-1:0] m_cw    = '0;

  always @(posedge clk) begin
    if (rst) m_valid <= 1'b0;
    else if (in_valid && (!m_valid || out_ready)) begin
      m_valid <= 1'b1;
      m_cw    <= ref_encode(in_data);
    end else if (out_ready) m_valid <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, compare once inputs settle, then pass the next rising edge.
  task automatic step(input bit v, input logic [K-1:0] d, input bit r, input bit rs);
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = r; rst = rs;
    #1;
    chk(in_ready == (!m_valid || out_ready), "R5 in_ready", L'(in_ready), L'(!m_valid || out_ready));
    chk(out_valid == m_valid, "R4/R7 out_valid", L'(out_valid), L'(m_valid));
    if (m_valid && out_valid) begin
      chk(out_cw[K-1:0] == m_cw[K-1:0], "R1 data field", out_cw, m_cw);
      chk(out_cw == m_cw, "R2/R6/R8 codeword", out_cw, m_cw);
      chk(^out_cw[L-1:K] == 1'b0, "R3 parity sum", L'(^out_cw[L-1:K]), '0);
      if ($countones(m_cw[K-1:0]) == 1)
        chk($countones(out_cw) == 3, "R9 weight", L'($countones(out_cw)), L'(3));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    step(0, '0, 0, 1);
    step(0, '0, 0, 1);
    step(0, '0, 0, 0);            // reset state, R7
    // R9 / R2: each single data bit, back-to-back (R8)
    for (int b = 0; b < K; b++) step(1, K'(1) << b, 1, 0);
    step(0, '0, 1, 0);
    // assorted patterns, R1 R2 R3
    step(1, '1, 1, 0);
    step(1, K'('h2AA), 1, 0);
    step(1, K'('h155), 1, 0);
    step(1, K'('h0F0), 1, 0);
    step(0, '0, 1, 0);
    // R6: stall with changing data
    step(1, K'('h3C3), 0, 0);
    for (int s = 0; s < 6; s++) step(1, K'(s * 97 + 5), 0, 0);
    step(1, K'('h111), 1, 0);     // release; accept 'h111 same cycle
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    // R7: reset while a word is pending
    step(1, K'('h0AB), 0, 0);
    step(1, K'('h0CD), 0, 1);
    step(0, '0, 0, 0);
    step(0, '0, 1, 0);
    // R8: streaming with intermittent backpressure
    for (int t = 0; t < 40; t++) step(1, K'(t * 37 + 11), (t % 3) != 0, 0);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule